// File: doc/BRIEF.md
# Serial Port Receive Interrupt Logic

This block sits in the register file of a serial port and turns each incoming character into an interrupt request for the processor. An external deserializer delivers a one-cycle strobe along with the received byte. The block latches that byte into a receive holding register and sets a pending flag. The flag records that a receive interrupt is in progress.

The request line is high while the flag is set and the receive enable bit is on. The flag stays set until the processor reads the holding register. That read returns the byte and completes the interrupt in progress, so no separate clear command is needed.

Software reaches the block through a 3-bit register offset with read and write strobes:

- Offset 0 is the holding register.
- Offset 1 is the interrupt enable register. It has room for four sources, but only the receive source is active.
- Offset 5 carries a data-ready bit that mirrors the pending flag.

Top module: `uart_rx_irq`

## Requirements
- R1: After synchronous reset the enable register, the pending flag and the holding register are all zero, and `irq` is low.
- R2: A cycle with `rx_strobe` high stores `rx_byte` into the holding register and sets the pending flag at that clock edge.
- R3: `irq` is high exactly when the pending flag is set and enable bit 0 is set. With bit 0 clear, no character ever raises `irq`.
- R4: A read at offset 0 returns the holding register on `bus_rdata`. At the clock edge of that read, the pending flag clears unless R5 applies.
- R5: If `rx_strobe` and a read at offset 0 fall in the same cycle, the read returns the previous byte, the new byte is stored, and the pending flag stays set.
- R6: A write at offset 1 stores bits 3..0 of `bus_wdata`, and a read at offset 1 returns them with bits 7..4 as zero. Bits 3..1 have no effect on `irq`.
- R7: Clearing enable bit 0 drops `irq` but keeps the pending flag, so re-enabling raises `irq` again without a new character.
- R8: A read at offset 5 returns the pending flag in bit 0 and zero in bits 7..1.
- R9: Reads at offsets other than 0 leave the pending flag unchanged and return zero at offsets 2, 3, 4, 6 and 7.
- R10: Writes at offsets other than 1 change no state.
- R11: A character that arrives while the flag is already pending replaces the held byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_strobe | input | 1 | One-cycle strobe: a character was received |
| rx_byte | input | 8 | Received character, valid with `rx_strobe` |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe; a read at offset 0 completes the pending interrupt |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` (combinational) |
| irq | output | 1 | Receive interrupt request |

## Verification
Random traffic mixes character strobes, reads and writes at all eight offsets, and enable values. This shows whether the pending flag clears only on a data read, and whether the request tracks the flag and the enable together. Directed sequences cover these cases:

- A character arriving with the enable off, then the enable turned on. This separates a masked request from a lost flag.
- A strobe and a data read in the same cycle. This separates the correct ordering from a clear that wins.
- Two characters before a read. This shows overwrite of the held byte.
- Writes of the spare enable bits. These show that the spare bits read back but have no effect on `irq`.

// File: rtl/uart_rxi_pkg.sv
package uart_rxi_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int SRC_COUNT = 4;

    localparam logic [ADDR_W-1:0] OFF_DATA   = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_ENABLE = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 3'd5;

    typedef struct packed {
        logic [SRC_COUNT-2:0] spare;
        logic                 rx_en;
    } enable_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } bus_req_t;

    function automatic logic hits(input bus_req_t req, input logic [ADDR_W-1:0] off,
                                  input logic is_read);
        return (is_read ? req.rd : req.wr) && (req.addr == off);
    endfunction
endpackage

// File: rtl/rxi_enable_reg.sv
module rxi_enable_reg
    import uart_rxi_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output enable_t       en_q
);
    logic unused_hi;
    assign unused_hi = ^wdata[DW-1:SRC_COUNT];

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (wr_en) en_q <= enable_t'(wdata[SRC_COUNT-1:0]);
    end
endmodule

// File: rtl/rxi_hold.sv
module rxi_hold
    import uart_rxi_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_strobe,
    input  logic [DW-1:0] rx_byte,
    input  logic          data_read,
    output logic [DW-1:0] hold_q,
    output logic          pend_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (rx_strobe) hold_q <= rx_byte;
            if (rx_strobe)      pend_q <= 1'b1;
            else if (data_read) pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rxi_read_mux.sv
module rxi_read_mux
    import uart_rxi_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] hold,
    input  enable_t       en,
    input  logic          pend,
    output logic [DW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_DATA:   rdata = hold;
            OFF_ENABLE: rdata[SRC_COUNT-1:0] = en;
            OFF_STATUS: rdata[0] = pend;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
    import uart_rxi_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_strobe,
    input  logic [DW-1:0] rx_byte,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    bus_req_t        req;
    enable_t         ier_q;
    logic [DW-1:0]   hold_q;
    logic            pend_q;

    assign req = '{rd: bus_rd, wr: bus_wr, addr: bus_addr};

    rxi_enable_reg #(.DW(DW)) u_en (
        .clk(clk), .rst(rst),
        .wr_en(hits(req, OFF_ENABLE, 1'b0)),
        .wdata(bus_wdata), .en_q(ier_q)
    );

    rxi_hold #(.DW(DW)) u_hold (
        .clk(clk), .rst(rst),
        .rx_strobe(rx_strobe), .rx_byte(rx_byte),
        .data_read(hits(req, OFF_DATA, 1'b1)),
        .hold_q(hold_q), .pend_q(pend_q)
    );

    rxi_read_mux #(.DW(DW), .AW(AW)) u_mux (
        .addr(bus_addr), .hold(hold_q), .en(ier_q), .pend(pend_q),
        .rdata(bus_rdata)
    );

    assign irq = pend_q & ier_q.rx_en;
endmodule

// File: rtl/uart_rx_irq_chk.sv
module uart_rx_irq_chk
    import uart_rxi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_strobe,
    input logic [DATA_W-1:0] rx_byte,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              pend,
    input enable_t           ier,
    input logic [DATA_W-1:0] hold
);
    assert_strobe_latches_R2: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |=> pend && hold == $past(rx_byte));

    assert_read_completes_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_DATA && !rx_strobe) |=> !pend);

    assert_strobe_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_DATA && rx_strobe) |=> pend);

    assert_other_access_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (!rx_strobe && !(bus_rd && bus_addr == OFF_DATA)) |=> $stable(pend));

    assert_enable_write_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_ENABLE) |=> ier == $past(bus_wdata[SRC_COUNT-1:0]));

    assert_enable_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == OFF_ENABLE) |=> $stable(ier));

    always_comb begin
        if (!rst) assert_irq_gated_R3: assert (!irq || (pend && ier.rx_en));
    end
endmodule

bind uart_rx_irq uart_rx_irq_chk u_chk (
    .clk(clk), .rst(rst), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .irq(irq), .pend(pend_q), .ier(ier_q), .hold(hold_q)
);

// File: tb/uart_rx_irq_test.sv
module uart_rx_irq_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       rx_strobe;
    logic [7:0] rx_byte;
    logic [2:0] bus_addr;
    logic       bus_rd, bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench model built from the requirements
    logic [3:0] m_en;
    logic       m_pend;
    logic [7:0] m_hold;

    always #2 clk = ~clk;

    uart_rx_irq uut (
        .clk(clk), .rst(rst), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%02h expected=%02h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd0:    return m_hold;
            3'd1:    return {4'b0, m_en};
            3'd5:    return {7'b0, m_pend};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_req(input logic [2:0] a);
        case (a)
            3'd0:    return "R4";
            3'd1:    return "R6";
            3'd5:    return "R8";
            default: return "R9";
        endcase
    endfunction

    // one bus cycle: drive at negedge, check combinational outputs, then model the edge
    task automatic cyc(input logic cv, input logic [7:0] cd, input logic [2:0] a,
                       input logic rd, input logic wr, input logic [7:0] wd);
        @(negedge clk);
        rx_strobe = cv; rx_byte = cd; bus_addr = a;
        bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        #1;
        chk("R3", {7'b0, irq}, {7'b0, m_pend & m_en[0]});
        if (rd) chk(rd_req(a), bus_rdata, exp_rdata(a));
        @(posedge clk);
        if (cv) begin m_hold = cd; m_pend = 1'b1; end
        else if (rd && a == 3'd0) m_pend = 1'b0;
        if (wr && a == 3'd1) m_en = wd[3:0];
    endtask

    task automatic idle();
        cyc(1'b0, 8'h00, 3'd7, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; rx_strobe = 0; rx_byte = 0; bus_addr = 0;
        bus_rd = 0; bus_wr = 0; bus_wdata = 0;
        m_en = 0; m_pend = 0; m_hold = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        #1;
        chk("R1", {7'b0, irq}, 8'h00);
        bus_addr = 3'd0; #1 chk("R1", bus_rdata, 8'h00);
        bus_addr = 3'd1; #1 chk("R1", bus_rdata, 8'h00);
        bus_addr = 3'd5; #1 chk("R1", bus_rdata, 8'h00);

        // R3: character with enable off stays masked; R7: enabling raises irq
        cyc(1, 8'hA5, 3'd7, 0, 0, 0);
        #1 chk("R3", {7'b0, irq}, 8'h00);
        cyc(0, 0, 3'd1, 0, 1, 8'h01);
        #1 chk("R7", {7'b0, irq}, 8'h01);
        // R7: clearing enable drops irq, flag kept
        cyc(0, 0, 3'd1, 0, 1, 8'h00);
        #1 chk("R7", {7'b0, irq}, 8'h00);
        cyc(0, 0, 3'd5, 1, 0, 0);
        cyc(0, 0, 3'd1, 0, 1, 8'h01);
        #1 chk("R7", {7'b0, irq}, 8'h01);
        // R11: overwrite while pending
        cyc(1, 8'h3C, 3'd7, 0, 0, 0);
        cyc(0, 0, 3'd0, 1, 0, 0);
        #1 chk("R11", {7'b0, irq}, 8'h00);
        // R5: strobe and data read together
        cyc(1, 8'h11, 3'd7, 0, 0, 0);
        cyc(1, 8'h22, 3'd0, 1, 0, 0);
        #1 chk("R5", {7'b0, irq}, 8'h01);
        cyc(0, 0, 3'd0, 1, 0, 0);
        // R6: spare bits read back, no effect
        cyc(0, 0, 3'd1, 0, 1, 8'hFE);
        cyc(1, 8'h77, 3'd1, 1, 0, 0);
        #1 chk("R6", {7'b0, irq}, 8'h00);
        // R10: write to data offset changes nothing
        cyc(0, 0, 3'd0, 0, 1, 8'h99);
        cyc(0, 0, 3'd0, 1, 0, 0);
        cyc(0, 0, 3'd1, 0, 1, 8'h01);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic cv, rd, wr;
            logic [2:0] a;
            cv = ($urandom % 4) == 0;
            rd = ($urandom % 2) == 0;
            wr = !rd && (($urandom % 3) == 0);
            a  = 3'($urandom);
            cyc(cv, 8'($urandom), a, rd, wr, 8'($urandom));
            if (i % 200 == 0) idle();
        end
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired got=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule